// File: doc/BRIEF.md
# Out-of-Order Operand Wait Pool

This block is a small pool of waiting slots placed in front of one functional unit of an out-of-order core. The decoder drops an instruction into a free slot together with its opcode, the tag under which its result will later be announced, and two source operands. Each operand arrives either as a finished value or as the tag of an instruction that has not yet produced its result.

The pool listens to a single result broadcast bus carrying a tag and a value. Any waiting operand whose tag matches a broadcast swaps the tag for the value. Once both operands of a slot hold values, the slot becomes a candidate for issue. Among the candidates, the one allocated earliest is offered to the functional unit on a valid/ready handshake. Slots therefore leave in data-ready order rather than program order. A flush input empties the pool in one cycle.

Top module: `rsv_station`

## Requirements
- R1: After reset the pool is empty: `issue_valid` is 0 and `full` is 0.
- R2: When `alloc_valid` is 1, `full` is 0 and `flush` is 0, the instruction is stored at the clock edge, and its ready operand values reappear unchanged on `issue_a` / `issue_b` when it issues. An operand whose `*_rdy` bit is 1 takes its value from `*_val`. An operand whose `*_rdy` bit is 0 waits on the tag in `*_tag`.
- R3: A slot is never offered while either of its operands still holds a tag.
- R4: When `cdb_valid` is 1, every waiting operand in the pool whose tag equals `cdb_tag` takes `cdb_data` as its value at that clock edge.
- R5: A broadcast that matches a waiting operand in the same cycle that operand is being allocated is captured at allocation.
- R6: An operand woken by a broadcast in cycle c makes its slot offerable no earlier than cycle c+1, so a dependent instruction issues two cycles after its producer.
- R7: When several slots are ready, the one allocated earliest is offered. A younger ready slot is offered ahead of an older slot that is still waiting.
- R8: A slot leaves the pool only in a cycle where `issue_valid` and `issue_ready` are both 1. While `issue_ready` is 0, `issue_valid` stays asserted.
- R9: `full` is 1 when all ENTRIES slots hold instructions. An allocation attempted while `full` is 1 is ignored.
- R10: While `flush` is 1, `issue_valid` is 0 and any allocation in that cycle is dropped. After that edge the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all slots |
| alloc_valid | input | 1 | Decoder presents an instruction |
| alloc_op | input | OP_W | Opcode |
| alloc_dst | input | TAG_W | Tag naming the result |
| alloc_a_rdy | input | 1 | Operand A holds a value |
| alloc_a_tag | input | TAG_W | Producer tag of operand A |
| alloc_a_val | input | DATA_W | Value of operand A |
| alloc_b_rdy | input | 1 | Operand B holds a value |
| alloc_b_tag | input | TAG_W | Producer tag of operand B |
| alloc_b_val | input | DATA_W | Value of operand B |
| full | output | 1 | No free slot |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Value of the broadcast result |
| issue_valid | output | 1 | A ready slot is offered |
| issue_ready | input | 1 | Functional unit accepts |
| issue_op | output | OP_W | Opcode of offered slot |
| issue_dst | output | TAG_W | Result tag of offered slot |
| issue_a | output | DATA_W | Operand A value |
| issue_b | output | DATA_W | Operand B value |

## Verification
The assertions assume that the decoder never reuses a result tag still pending in the pool. They also assume that a tag is broadcast at most once while operands wait on it. Under those conditions the allocation-rank ages stay distinct and the capture check is meaningful. The stimulus gives every in-flight result its own tag and broadcasts each tag once. It raises `flush` only between otherwise well-formed sequences, so no scenario relies on an allocation being accepted while the pool is full.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } rs_opnd_t;

    // Replace a pending tag by a broadcast value when the tags match.
    function automatic rs_opnd_t rs_snoop(rs_opnd_t o, logic hit_v,
                                          logic [TAG_W-1:0] hit_tag,
                                          logic [DATA_W-1:0] hit_data);
        rs_opnd_t r;
        r = o;
        if (!o.rdy && hit_v && (o.tag == hit_tag)) begin
            r.rdy = 1'b1;
            r.val = hit_data;
        end
        return r;
    endfunction

endpackage

// File: rtl/rsv_slot.sv
module rsv_slot
    import rs_pkg::*;
#(
    parameter int AGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_we,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  rs_opnd_t          alloc_a,
    input  rs_opnd_t          alloc_b,
    input  logic [AGE_W-1:0]  alloc_age,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              leave,
    input  logic              issue_fire,
    input  logic [AGE_W-1:0]  issue_age,
    output logic              valid,
    output logic              ready,
    output logic [AGE_W-1:0]  age,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);

    typedef struct packed {
        logic             valid;
        logic [OP_W-1:0]  op;
        logic [TAG_W-1:0] dst;
        rs_opnd_t         a;
        rs_opnd_t         b;
        logic [AGE_W-1:0] age;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d   = slot_q;
        slot_d.a = rs_snoop(slot_q.a, cdb_valid, cdb_tag, cdb_data);
        slot_d.b = rs_snoop(slot_q.b, cdb_valid, cdb_tag, cdb_data);
        // an older slot left: close the gap in the ranking
        if (slot_q.valid && issue_fire && (slot_q.age > issue_age)) begin
            slot_d.age = slot_q.age - 1'b1;
        end
        if (leave) begin
            slot_d.valid = 1'b0;
        end
        if (alloc_we) begin
            slot_d.valid = 1'b1;
            slot_d.op    = alloc_op;
            slot_d.dst   = alloc_dst;
            slot_d.a     = rs_snoop(alloc_a, cdb_valid, cdb_tag, cdb_data);
            slot_d.b     = rs_snoop(alloc_b, cdb_valid, cdb_tag, cdb_data);
            slot_d.age   = alloc_age;
        end
        if (flush) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign ready = slot_q.valid && slot_q.a.rdy && slot_q.b.rdy;
    assign age   = slot_q.age;
    assign op    = slot_q.op;
    assign dst   = slot_q.dst;
    assign a_val = slot_q.a.val;
    assign b_val = slot_q.b.val;

    // R3
    leave_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leave |-> (slot_q.valid && slot_q.a.rdy && slot_q.b.rdy));

    // R4
    snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !slot_q.a.rdy && !alloc_we && cdb_valid && (cdb_tag == slot_q.a.tag))
        |=> (slot_q.a.rdy && (slot_q.a.val == $past(cdb_data))));

endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int N     = 4,
    parameter int AGE_W = 2
) (
    input  logic [N-1:0]            req,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic [N-1:0]            grant,
    output logic                    any
);

    logic [AGE_W-1:0] best;

    // lowest rank among requesters is the earliest allocated
    always_comb begin
        grant = '0;
        any   = 1'b0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || (age[i] < best))) begin
                best     = age[i];
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rs_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    output logic              full,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [OP_W-1:0]   issue_op,
    output logic [TAG_W-1:0]  issue_dst,
    output logic [DATA_W-1:0] issue_a,
    output logic [DATA_W-1:0] issue_b
);

    localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]              slot_valid, slot_ready, grant, alloc_sel;
    logic [ENTRIES-1:0][AGE_W-1:0]   slot_age;
    logic [ENTRIES-1:0][OP_W-1:0]    slot_op;
    logic [ENTRIES-1:0][TAG_W-1:0]   slot_dst;
    logic [ENTRIES-1:0][DATA_W-1:0]  slot_a, slot_b;
    logic [CNT_W-1:0]                occ;
    logic [AGE_W-1:0]                alloc_age, issue_age;
    logic                            any_ready, alloc_fire, issue_fire, found;
    rs_opnd_t                        in_a, in_b;

    assign in_a = '{rdy: alloc_a_rdy, tag: alloc_a_tag, val: alloc_a_val};
    assign in_b = '{rdy: alloc_b_rdy, tag: alloc_b_tag, val: alloc_b_val};

    always_comb begin
        occ = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            occ = occ + CNT_W'(slot_valid[i]);
        end
    end

    assign full        = (occ == CNT_W'(ENTRIES));
    assign alloc_fire  = alloc_valid && !full && !flush;
    assign issue_valid = any_ready && !flush;
    assign issue_fire  = issue_valid && issue_ready;
    assign alloc_age   = AGE_W'(occ - CNT_W'(issue_fire));

    // lowest free slot takes the new instruction
    always_comb begin
        alloc_sel = '0;
        found     = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!slot_valid[i] && !found) begin
                alloc_sel[i] = alloc_fire;
                found        = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rsv_slot #(.AGE_W(AGE_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc_we   (alloc_sel[g]),
            .alloc_op   (alloc_op),
            .alloc_dst  (alloc_dst),
            .alloc_a    (in_a),
            .alloc_b    (in_b),
            .alloc_age  (alloc_age),
            .cdb_valid  (cdb_valid),
            .cdb_tag    (cdb_tag),
            .cdb_data   (cdb_data),
            .leave      (grant[g] && issue_fire),
            .issue_fire (issue_fire),
            .issue_age  (issue_age),
            .valid      (slot_valid[g]),
            .ready      (slot_ready[g]),
            .age        (slot_age[g]),
            .op         (slot_op[g]),
            .dst        (slot_dst[g]),
            .a_val      (slot_a[g]),
            .b_val      (slot_b[g])
        );
    end

    rsv_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_pick (
        .req   (slot_ready),
        .age   (slot_age),
        .grant (grant),
        .any   (any_ready)
    );

    always_comb begin
        issue_op  = '0;
        issue_dst = '0;
        issue_a   = '0;
        issue_b   = '0;
        issue_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) begin
                issue_op  = issue_op  | slot_op[i];
                issue_dst = issue_dst | slot_dst[i];
                issue_a   = issue_a   | slot_a[i];
                issue_b   = issue_b   | slot_b[i];
                issue_age = issue_age | slot_age[i];
            end
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~slot_ready) == '0));

    // R8
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready) |=> (issue_valid || flush));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));

    // R2
    alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !flush && !issue_fire) |=> (occ == $past(occ) + 1'b1));

    // R9
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !issue_fire && !flush) |=> full);

endmodule

// File: tb/rsv_station_bench.sv
module rsv_station_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [3:0]  alloc_op = '0, alloc_dst = '0, alloc_a_tag = '0, alloc_b_tag = '0;
    logic        alloc_a_rdy = 1'b0, alloc_b_rdy = 1'b0;
    logic [15:0] alloc_a_val = '0, alloc_b_val = '0;
    logic        full;
    logic        cdb_valid = 1'b0;
    logic [3:0]  cdb_tag = '0;
    logic [15:0] cdb_data = '0;
    logic        issue_valid;
    logic        issue_ready = 1'b0;
    logic [3:0]  issue_op, issue_dst;
    logic [15:0] issue_a, issue_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsv_station u_rsv_station (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag), .alloc_a_val(alloc_a_val),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag), .alloc_b_val(alloc_b_val),
        .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_a(issue_a), .issue_b(issue_b)
    );

    typedef struct packed {
        logic        av;  logic [3:0] op; logic [3:0] dst;
        logic        ar;  logic [3:0] at; logic [15:0] aval;
        logic        br;  logic [3:0] bt; logic [15:0] bval;
        logic        cv;  logic [3:0] ct; logic [15:0] cd;
        logic        ir;
        logic        ev;  logic [3:0] edst; logic [15:0] ea; logic [15:0] eb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,4'd1,4'd1, 1'b1,4'd0,16'd10, 1'b1,4'd0,16'd20, 1'b0,4'd0,16'd0,  1'b0, 1'b0,4'd0,16'd0,16'd0},  // R1 empty
        '{1'b1,4'd2,4'd2, 1'b0,4'd1,16'd0,  1'b1,4'd0,16'd5,  1'b0,4'd0,16'd0,  1'b0, 1'b1,4'd1,16'd10,16'd20}, // R2
        '{1'b1,4'd3,4'd3, 1'b1,4'd0,16'd7,  1'b0,4'd5,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd1,16'd10,16'd20}, // R8 take
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1,4'd1,16'd30, 1'b1, 1'b0,4'd0,16'd0,16'd0},  // R3 R6
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1,4'd5,16'd40, 1'b0, 1'b1,4'd2,16'd30,16'd5},  // R4 R6
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0, 1'b1,4'd2,16'd30,16'd5},  // R7 R8
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd2,16'd30,16'd5},  // R7
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd3,16'd7,16'd40},  // R4
        '{1'b1,4'd4,4'd4, 1'b0,4'd6,16'd0,  1'b1,4'd0,16'd1,  1'b0,4'd0,16'd0,  1'b0, 1'b0,4'd0,16'd0,16'd0},
        '{1'b1,4'd5,4'd5, 1'b1,4'd0,16'd2,  1'b1,4'd0,16'd3,  1'b0,4'd0,16'd0,  1'b0, 1'b0,4'd0,16'd0,16'd0},  // R3
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd5,16'd2,16'd3},   // R7 younger first
        '{1'b1,4'd6,4'd6, 1'b0,4'd6,16'd0,  1'b1,4'd0,16'd9,  1'b1,4'd6,16'd50, 1'b0, 1'b0,4'd0,16'd0,16'd0},  // R5 alloc capture
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd4,16'd50,16'd1},  // R7 R4
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b1, 1'b1,4'd6,16'd50,16'd9},  // R5
        '{1'b0,4'd0,4'd0, 1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0,4'd0,16'd0,  1'b0, 1'b0,4'd0,16'd0,16'd0}   // R8 left
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; cdb_valid = 1'b0; issue_ready = 1'b0; flush = 1'b0;
    endtask

    task automatic set_alloc(input logic [3:0] dst, input logic ar, input logic [3:0] at,
                             input logic [15:0] av, input logic br, input logic [15:0] bv);
        alloc_valid = 1'b1; alloc_op = dst; alloc_dst = dst;
        alloc_a_rdy = ar; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_rdy = br; alloc_b_tag = 4'd0; alloc_b_val = bv;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(issue_valid == 1'b0, "R1 issue_valid", 64'(issue_valid), 64'd0);
        chk(full == 1'b0, "R1 full", 64'(full), 64'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            alloc_valid = VECS[i].av; alloc_op = VECS[i].op; alloc_dst = VECS[i].dst;
            alloc_a_rdy = VECS[i].ar; alloc_a_tag = VECS[i].at; alloc_a_val = VECS[i].aval;
            alloc_b_rdy = VECS[i].br; alloc_b_tag = VECS[i].bt; alloc_b_val = VECS[i].bval;
            cdb_valid = VECS[i].cv; cdb_tag = VECS[i].ct; cdb_data = VECS[i].cd;
            issue_ready = VECS[i].ir;
            #1;
            chk(issue_valid == VECS[i].ev, $sformatf("R2-table row %0d valid", i),
                64'(issue_valid), 64'(VECS[i].ev));
            if (VECS[i].ev) begin
                chk(issue_dst == VECS[i].edst && issue_a == VECS[i].ea && issue_b == VECS[i].eb,
                    $sformatf("R7 table row %0d payload", i),
                    {32'd0, issue_dst, issue_a[11:0], issue_b}, {32'd0, VECS[i].edst, VECS[i].ea[11:0], VECS[i].eb});
            end
            tick();
        end
        idle_inputs();

        // R9: fill with four waiting slots
        for (int k = 0; k < 4; k++) begin
            set_alloc(4'(8 + k), 1'b0, 4'd7, 16'd0, 1'b1, 16'(k));
            tick();
        end
        idle_inputs();
        #1;
        chk(full == 1'b1, "R9 full after four", 64'(full), 64'd1);
        set_alloc(4'd12, 1'b1, 4'd0, 16'd77, 1'b1, 16'd78);
        tick();
        idle_inputs();
        #1;
        chk(issue_valid == 1'b0, "R9 blocked alloc not issued", 64'(issue_valid), 64'd0);
        chk(full == 1'b1, "R9 still full", 64'(full), 64'd1);
        cdb_valid = 1'b1; cdb_tag = 4'd7; cdb_data = 16'd99;
        #1;
        chk(issue_valid == 1'b0, "R6 no same-cycle wakeup", 64'(issue_valid), 64'd0);
        tick();
        idle_inputs();
        #1;
        // R8 hold while not ready
        chk(issue_valid && issue_dst == 4'd8, "R8 offered", 64'(issue_dst), 64'd8);
        tick();
        chk(issue_valid && issue_dst == 4'd8, "R8 held", 64'(issue_dst), 64'd8);
        for (int k = 0; k < 4; k++) begin
            issue_ready = 1'b1;
            #1;
            chk(issue_valid && issue_dst == 4'(8 + k) && issue_a == 16'd99 && issue_b == 16'(k),
                "R7 R4 drain order", 64'(issue_dst), 64'(8 + k));
            tick();
        end
        issue_ready = 1'b0;
        #1;
        chk(issue_valid == 1'b0, "R9 ignored slot absent", 64'(issue_valid), 64'd0);

        // R10 flush with a full pool
        for (int k = 0; k < 4; k++) begin
            set_alloc(4'(1 + k), 1'b1, 4'd0, 16'(k), 1'b1, 16'(k));
            tick();
        end
        idle_inputs();
        flush = 1'b1;
        issue_ready = 1'b1;
        set_alloc(4'd13, 1'b1, 4'd0, 16'd5, 1'b1, 16'd6);
        #1;
        chk(issue_valid == 1'b0, "R10 no offer during flush", 64'(issue_valid), 64'd0);
        tick();
        idle_inputs();
        #1;
        chk(full == 1'b0, "R10 empty after flush", 64'(full), 64'd0);
        chk(issue_valid == 1'b0, "R10 flushed alloc dropped", 64'(issue_valid), 64'd0);
        tick();
        chk(issue_valid == 1'b0, "R10 still empty", 64'(issue_valid), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule